// File: doc/BRIEF.md
# MMU Page-Entry Staging and TLB Load Unit

This block holds the software-visible state of a software-managed MMU. It has three staging registers that describe one page: a high word with the virtual page number and address-space identifier, a low word with the physical page number and attribute flags, and a small assist word. It also has a control register. Software writes each register through a simple select/write/read port. A write keeps only the bits that the register implements.

A one-cycle load strobe copies the staged words into the unified TLB entry that the control register's replacement counter points at. On the way, the words are split into separate entry fields. Writing the control register with its invalidate bit set clears the valid flag of every unified TLB entry and every instruction TLB entry.

The translation side fills the instruction TLB valid bits through a fill vector. A read port exposes any unified TLB entry by index, including the decoded page size. This port lets the surrounding logic, and the bench, observe the stored state.

Top module: `mmu_ctl`

## Requirements
- R1: After reset all four registers read 0, every instruction TLB valid bit is 0 and every unified TLB entry reads 0 in all fields.
- R2: A write with select 0 (page high) stores the write data ANDed with 0xFFFFFCFF. The stored value reads back on select 0 from the next cycle.
- R3: A write with select 1 (page low) stores the write data ANDed with 0x1FFFFDFF. The stored value reads back on select 1.
- R4: A write with select 2 (page assist) stores only write-data bits 3:0. Reads on select 2 return them zero-extended.
- R5: A write with select 3 (control) takes the replacement counter from bits 15:10, the boundary from bits 23:18 and the LRU field from bits 31:26. It keeps bits 0, 8 and 9 as plain stored bits. A read on select 3 returns those bits with the three fields at the same positions and every other bit 0, including invalidate bit 2.
- R6: A load strobe writes the unified TLB entry indexed by the replacement counter. The entry gets VPN = high AND 0xFFFFFC00, ASID = high bits 7:0, PPN = low AND 0x1FFFFC00, flags = low bits 8:0 and assist = assist bits 3:0. The control register, the instruction TLB and all other entries stay unchanged.
- R7: A control write with bit 2 set clears flag bit 8 (valid) of every unified TLB entry and every instruction TLB valid bit at the same clock edge. All other entry fields are kept.
- R8: When an invalidate coincides with a load strobe or an instruction TLB fill, the load still writes its fields. Every valid flag, including the loaded entry's flag, still ends up cleared.
- R9: Each set bit of the fill vector sets the matching instruction TLB valid bit, which then stays set until an invalidate or a reset.
- R10: The entry read port gives page size as {flags bit 7, flags bit 4}: 0 = 1K, 1 = 4K, 2 = 64K, 3 = 1M.
- R11: A load strobe uses the staged registers and counter as they were before the same clock edge. A register write in that cycle does not affect the loaded entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 high, 1 low, 2 assist, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tlb_load | input | 1 | Load staged page entry into the unified TLB |
| itlb_fill | input | ITLB_N | Instruction TLB valid set vector |
| itlb_valid | output | ITLB_N | Instruction TLB valid flags |
| ent_idx | input | IDX_W | Unified TLB entry read index |
| ent_vpn | output | 32 | Entry virtual page number, in place |
| ent_asid | output | 8 | Entry address-space identifier |
| ent_ppn | output | 32 | Entry physical page number, in place |
| ent_flags | output | 9 | Entry flags, valid at bit 8 |
| ent_size | output | 2 | Decoded page size code |
| ent_assist | output | 4 | Entry assist bits |

## Verification
The bench builds the block with its default sizes of 64 unified and 4 instruction entries. At these sizes the 6-bit replacement counter covers the whole entry array, so one sweep can load every entry with a distinct arithmetic pattern and then read every entry back. Mask behaviour is swept with walking-one and dense patterns on each register. The control fields are swept over all 64 counter values. The same-edge cases are driven in single cycles: a write racing a load, and an invalidate racing a load and a fill.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
    localparam logic [31:0] HI_KEEP  = 32'hFFFF_FCFF;
    localparam logic [31:0] LO_KEEP  = 32'h1FFF_FDFF;
    localparam logic [31:0] CTL_KEEP = 32'h0000_0301;
    localparam int unsigned PTR_W     = 6;
    localparam int unsigned CNT_LSB   = 10;
    localparam int unsigned BND_LSB   = 18;
    localparam int unsigned LRU_LSB   = 26;
    localparam int unsigned INV_BIT   = 2;
    localparam int unsigned VALID_BIT = 8;

    typedef enum logic [1:0] {
        SEL_HI  = 2'd0,
        SEL_LO  = 2'd1,
        SEL_AS  = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [21:0] vpn;
        logic [7:0]  asid;
        logic [18:0] ppn;
        logic [8:0]  flags;
        logic [3:0]  assist;
    } tlb_ent_t;
endpackage

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output tlb_ent_t         staged,
    output logic [PTR_W-1:0] repl_cnt,
    output logic             inv_now
);
    typedef struct packed {
        logic [31:0]      hi;
        logic [31:0]      lo;
        logic [3:0]       as;
        logic [31:0]      ctl;
        logic [PTR_W-1:0] cnt;
        logic [PTR_W-1:0] bnd;
        logic [PTR_W-1:0] lru;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (reg_sel_e'(sel))
                SEL_HI:  r_d.hi = wdata & HI_KEEP;
                SEL_LO:  r_d.lo = wdata & LO_KEEP;
                SEL_AS:  r_d.as = wdata[3:0];
                SEL_CTL: begin
                    r_d.ctl = wdata & CTL_KEEP;
                    r_d.cnt = wdata[CNT_LSB +: PTR_W];
                    r_d.bnd = wdata[BND_LSB +: PTR_W];
                    r_d.lru = wdata[LRU_LSB +: PTR_W];
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_HI:  rdata = r_q.hi;
            SEL_LO:  rdata = r_q.lo;
            SEL_AS:  rdata = {28'b0, r_q.as};
            SEL_CTL: rdata = r_q.ctl
                           | (32'(r_q.cnt) << CNT_LSB)
                           | (32'(r_q.bnd) << BND_LSB)
                           | (32'(r_q.lru) << LRU_LSB);
            default: rdata = '0;
        endcase
    end

    assign inv_now  = wr_en && (reg_sel_e'(sel) == SEL_CTL) && wdata[INV_BIT];
    assign repl_cnt = r_q.cnt;
    assign staged   = '{vpn:    r_q.hi[31:10],
                        asid:   r_q.hi[7:0],
                        ppn:    r_q.lo[28:10],
                        flags:  r_q.lo[8:0],
                        assist: r_q.as};
endmodule

// File: rtl/mmu_utlb_store.sv
module mmu_utlb_store
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  tlb_ent_t         load_ent,
    input  logic             inv,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_ent_t         rd_ent
);
    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) s_d.ent[load_idx] = load_ent;
        if (inv) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                s_d.ent[i].flags[VALID_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_ent = s_q.ent[rd_idx];
endmodule

// File: rtl/mmu_itlb_valid.sv
module mmu_itlb_valid #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] fill,
    input  logic               inv,
    output logic [ENTRIES-1:0] valid
);
    typedef struct packed {
        logic [ENTRIES-1:0] v;
    } ivld_t;

    ivld_t v_d, v_q;

    always_comb begin
        v_d.v = v_q.v | fill;
        if (inv) v_d.v = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign valid = v_q.v;
endmodule

// File: rtl/mmu_ctl.sv
module mmu_ctl
    import mmu_ctl_pkg::*;
#(
    parameter int unsigned UTLB_N = 64,
    parameter int unsigned ITLB_N = 4,
    localparam int unsigned IDX_W = $clog2(UTLB_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tlb_load,
    input  logic [ITLB_N-1:0] itlb_fill,
    output logic [ITLB_N-1:0] itlb_valid,
    input  logic [IDX_W-1:0]  ent_idx,
    output logic [31:0]       ent_vpn,
    output logic [7:0]        ent_asid,
    output logic [31:0]       ent_ppn,
    output logic [8:0]        ent_flags,
    output logic [1:0]        ent_size,
    output logic [3:0]        ent_assist
);
    tlb_ent_t         staged;
    tlb_ent_t         rd_ent;
    logic [PTR_W-1:0] repl_cnt;
    logic             inv_now;

    mmu_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .staged   (staged),
        .repl_cnt (repl_cnt),
        .inv_now  (inv_now)
    );

    mmu_utlb_store #(.ENTRIES(UTLB_N)) u_utlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tlb_load),
        .load_idx (repl_cnt[IDX_W-1:0]),
        .load_ent (staged),
        .inv      (inv_now),
        .rd_idx   (ent_idx),
        .rd_ent   (rd_ent)
    );

    mmu_itlb_valid #(.ENTRIES(ITLB_N)) u_itlb (
        .clk   (clk),
        .rst_n (rst_n),
        .fill  (itlb_fill),
        .inv   (inv_now),
        .valid (itlb_valid)
    );

    assign ent_vpn    = {rd_ent.vpn, 10'b0};
    assign ent_asid   = rd_ent.asid;
    assign ent_ppn    = {3'b0, rd_ent.ppn, 10'b0};
    assign ent_flags  = rd_ent.flags;
    assign ent_size   = {rd_ent.flags[7], rd_ent.flags[4]};
    assign ent_assist = rd_ent.assist;
endmodule

// File: rtl/mmu_ctl_chk.sv
module mmu_ctl_chk #(
    parameter int unsigned ITLB_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [ITLB_N-1:0] itlb_fill,
    input logic [ITLB_N-1:0] itlb_valid
);
    localparam logic [31:0] CTL_VIS = 32'hFCFC_FF01;

    logic ctl_wr, inv_wr;
    assign ctl_wr = reg_we && (reg_sel == 2'd3);
    assign inv_wr = ctl_wr && reg_wdata[2];

    p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (itlb_valid == '0));

    p_hi_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd0) |=>
            (reg_sel != 2'd0 || reg_rdata == ($past(reg_wdata) & 32'hFFFF_FCFF)));

    p_ctl_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> ((reg_rdata & ~CTL_VIS) == 32'h0));

    p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3 && !ctl_wr) |=> (reg_sel != 2'd3 || $stable(reg_rdata)));

    p_inv_itlb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_wr |=> (itlb_valid == '0));

    p_fill_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_wr && itlb_fill != '0) |=>
            ((itlb_valid & $past(itlb_fill)) == $past(itlb_fill)));
endmodule

bind mmu_ctl mmu_ctl_chk #(.ITLB_N(ITLB_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .itlb_fill  (itlb_fill),
    .itlb_valid (itlb_valid)
);

// File: tb/mmu_ctl_bench.sv
module mmu_ctl_bench;
    localparam int UN = 64;
    localparam int IN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tlb_load = 1'b0;
    logic [IN-1:0] itlb_fill = '0;
    logic [IN-1:0] itlb_valid;
    logic [5:0]  ent_idx = '0;
    logic [31:0] ent_vpn, ent_ppn;
    logic [7:0]  ent_asid;
    logic [8:0]  ent_flags;
    logic [1:0]  ent_size;
    logic [3:0]  ent_assist;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] e_hi [UN];
    logic [31:0] e_lo [UN];
    logic [3:0]  e_as [UN];
    logic [31:0] cur_hi, cur_lo;
    logic [3:0]  cur_as;
    logic [31:0] cur_ctl;

    always #10 clk = ~clk;

    mmu_ctl u_mmu_ctl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tlb_load(tlb_load),
        .itlb_fill(itlb_fill), .itlb_valid(itlb_valid), .ent_idx(ent_idx),
        .ent_vpn(ent_vpn), .ent_asid(ent_asid), .ent_ppn(ent_ppn),
        .ent_flags(ent_flags), .ent_size(ent_size), .ent_assist(ent_assist)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        tlb_load = 1'b1;
        @(negedge clk);
        tlb_load = 1'b0;
    endtask

    task automatic chk_ent(input int i, input string tag, input logic valid_on);
        logic [8:0] fl;
        ent_idx = 6'(i);
        #1;
        fl = e_lo[i][8:0];
        if (!valid_on) fl[8] = 1'b0;
        chk({tag, " vpn"},    ent_vpn,           e_hi[i] & 32'hFFFF_FC00);
        chk({tag, " asid"},   32'(ent_asid),     e_hi[i] & 32'h0000_00FF);
        chk({tag, " ppn"},    ent_ppn,           e_lo[i] & 32'h1FFF_FC00);
        chk({tag, " flags"},  32'(ent_flags),    32'(fl));
        chk({tag, " assist"}, 32'(ent_assist),   32'(e_as[i]));
        chk("R10 size",       32'(ent_size),     32'({fl[7], fl[4]}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, pat, ctlw, x1, x2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 itlb", 32'(itlb_valid), 32'h0);
        for (int i = 0; i < UN; i++) begin
            ent_idx = 6'(i);
            #1;
            chk("R1 entry", ent_vpn | ent_ppn | 32'(ent_flags) | 32'(ent_asid) | 32'(ent_assist), 32'h0);
        end

        // R2, R3, R4: write masks with walking ones and dense patterns
        for (int k = 0; k < 34; k++) begin
            pat = (k < 32) ? (32'h1 << k) : ((k == 32) ? 32'hFFFF_FFFF : 32'hA5C3_5A3C);
            wr(2'd0, pat); rd(2'd0, v); chk("R2 high mask",   v, pat & 32'hFFFF_FCFF);
            wr(2'd1, pat); rd(2'd1, v); chk("R3 low mask",    v, pat & 32'h1FFF_FDFF);
            wr(2'd2, pat); rd(2'd2, v); chk("R4 assist mask", v, pat & 32'h0000_000F);
        end

        // R5: control fields and stored bits
        for (int k = 0; k < 64; k++) begin
            ctlw = (32'(k) << 10) | (32'(63 - k) << 18) | (32'(k ^ 21) << 26)
                 | 32'h0303_03FB;
            wr(2'd3, ctlw);
            rd(2'd3, v);
            chk("R5 control", v, ctlw & 32'hFCFC_FF01);
        end

        // R6, R10: load every entry with a distinct pattern
        for (int i = 0; i < UN; i++) begin
            cur_ctl = (32'(i) << 10) | (32'(i ^ 42) << 18) | 32'h0000_0101;
            cur_hi  = 32'(i) * 32'h9E37_79B1 ^ 32'(i);
            cur_lo  = (32'(i) * 32'h7F4A_7C15) | 32'h0000_0100;
            cur_as  = 4'(i * 7);
            wr(2'd3, cur_ctl);
            wr(2'd0, cur_hi);
            wr(2'd1, cur_lo);
            wr(2'd2, {28'b0, cur_as});
            pulse_load();
            e_hi[i] = cur_hi & 32'hFFFF_FCFF;
            e_lo[i] = cur_lo & 32'h1FFF_FDFF;
            e_as[i] = cur_as;
            rd(2'd3, v);
            chk("R6 control unchanged by load", v, cur_ctl & 32'hFCFC_FF01);
            chk("R6 itlb unchanged by load", 32'(itlb_valid), 32'h0);
        end
        for (int i = 0; i < UN; i++) chk_ent(i, "R6 entry", 1'b1);

        // R11: write racing a load; counter is 63
        x1 = 32'h1357_9BDF;
        x2 = 32'h2468_ACE0;
        wr(2'd0, x1);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = x2; tlb_load = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tlb_load = 1'b0;
        e_hi[63] = x1 & 32'hFFFF_FCFF;
        chk_ent(63, "R11 pre-edge staging", 1'b1);
        rd(2'd0, v);
        chk("R11 late write kept", v, x2 & 32'hFFFF_FCFF);
        chk_ent(62, "R11 neighbour", 1'b1);

        // R9: instruction TLB fill
        @(negedge clk); itlb_fill = 4'b0101;
        @(negedge clk); itlb_fill = 4'b0000;
        chk("R9 fill", 32'(itlb_valid), 32'h5);
        @(negedge clk); itlb_fill = 4'b1000;
        @(negedge clk); itlb_fill = 4'b0000;
        chk("R9 fill accumulate", 32'(itlb_valid), 32'hD);

        // R7: global invalidate
        wr(2'd3, (32'd63 << 10) | 32'h0000_0004);
        chk("R7 itlb cleared", 32'(itlb_valid), 32'h0);
        rd(2'd3, v);
        chk("R7 inv bit not stored", v, 32'd63 << 10);
        for (int i = 0; i < UN; i++) chk_ent(i, "R7 entry", 1'b0);

        // R8: invalidate racing a load and a fill; load uses counter 63
        cur_hi = 32'hCAFE_F00D;
        cur_lo = 32'h0BAD_F1FF;
        wr(2'd0, cur_hi);
        wr(2'd1, cur_lo);
        @(negedge clk); itlb_fill = 4'b0011;
        @(negedge clk); itlb_fill = 4'b0000;
        chk("R9 fill after invalidate", 32'(itlb_valid), 32'h3);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = (32'd7 << 10) | 32'h4;
        tlb_load = 1'b1; itlb_fill = 4'b1111;
        @(negedge clk);
        reg_we = 1'b0; tlb_load = 1'b0; itlb_fill = 4'b0000;
        e_hi[63] = cur_hi & 32'hFFFF_FCFF;
        e_lo[63] = cur_lo & 32'h1FFF_FDFF;
        chk("R8 itlb fill loses", 32'(itlb_valid), 32'h0);
        chk_ent(63, "R8 load fields, valid cleared", 1'b0);
        chk_ent(7, "R8 other entry", 1'b0);
        rd(2'd3, v);
        chk("R8 counter updated", v, 32'd7 << 10);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule